// File: doc/BRIEF.md
# Frequency-Change Watchdog with Recovery Lock

This block guards a system against a hang that follows a change of the clock frequency. Software arms it by setting the enable input. The count does not start at that point. It starts on the next frequency-change strobe. The count runs in units of a selectable scale. Each unit is a parameterised number of base time-base ticks, for example 150 ms or 2.5 s worth of 1 ms ticks. If the count runs out, the block does four things. It sets a sticky timeout status. It may pull the system reset line low for a fixed number of cycles. It forces the clock selector to a recovery setting. It then holds that setting against any further frequency update from the bus.

The recovery setting is one of two sources. The first is the strap code captured once after reset. The second is a programmed N/M pair. The lock stays in place until software clears the enable input. After that, bus updates take effect again.

The controller has four states, each named:
- `WD_IDLE`: disabled.
- `WD_ARMED`: enabled and waiting for a change.
- `WD_COUNT`: counting down.
- `WD_RECOVER`: expired and locked.

It has these transitions, each named:
- *arm*: IDLE to ARMED when enable is high.
- *start*: ARMED to COUNT on a change strobe.
- *restart*: COUNT to COUNT on a change strobe, which reloads the count.
- *expire*: COUNT to RECOVER on the last unit tick.
- *disarm*: any state to IDLE when enable is low.

Top module: `freq_watchdog`

## Requirements
- R1: After reset the block shows the following. `wd_status`=0, `rec_active`=0 and `sys_rst_pull`=0. `freq_src`=2'b00 (straps), with `freq_n`=0 and `freq_m`=0. `freq_fs` equals the `strap_fs` value present at the first clock after reset is released.
- R2: With enable high and no frequency-change strobe, no timeout ever occurs, however many base ticks arrive.
- R3: With `wd_long_scale`=0, the timeout occurs on the base tick numbered T*SHORT_TICKS after the strobe, where T is `wd_timeout`. A value of 0 behaves as 1. Status and `rec_active` are visible one clock after that tick.
- R4: With `wd_long_scale`=1, the same rule applies with LONG_TICKS base ticks per unit.
- R5: `wd_status` becomes 1 on timeout and stays 1. A `status_wr` with `status_wr_val`=1 clears it. A write with value 0 leaves it unchanged. A timeout in the same cycle as a clear wins.
- R6: A timeout with `wd_rst_en`=1 drives `sys_rst_pull`=1 for exactly PULSE_W cycles, starting in the same cycle as the status. With `wd_rst_en`=0 the pull stays 0.
- R7: On timeout the output selection is forced as follows. With `rec_sel`=0 it becomes `freq_src`=2'b00 with N=M=0. With `rec_sel`=1 it becomes `freq_src`=2'b10 with `freq_n`/`freq_m` taken from `rec_n`/`rec_m`.
- R8: While `rec_active`=1, `upd_valid` changes none of `freq_src`, `freq_n` and `freq_m`. Outside recovery, an update gives `freq_src`=2'b01 and the supplied N/M on the next clock.
- R9: Clearing enable stops the count and reloads it, and leaves recovery. A later count needs a fresh strobe and runs the full programmed length.
- R10: A strobe while counting restarts the full programmed count, including the unit prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_tick | input | 1 | One-cycle pulse from the time base |
| wd_enable | input | 1 | Arm bit; low stops, reloads and unlocks |
| wd_long_scale | input | 1 | Unit scale select: 0 short, 1 long |
| wd_timeout | input | TIMEOUT_W | Programmed count in units |
| wd_rst_en | input | 1 | Allow a reset pulse on timeout |
| status_wr | input | 1 | Write strobe for the status bit |
| status_wr_val | input | 1 | Written value; 1 clears status |
| freq_change | input | 1 | Frequency-change strobe |
| rec_sel | input | 1 | Recovery source: 0 straps, 1 N/M |
| rec_n | input | N_W | Recovery N value |
| rec_m | input | M_W | Recovery M value |
| strap_fs | input | FS_W | Strap code, captured once after reset |
| upd_valid | input | 1 | Bus frequency update strobe |
| upd_n | input | N_W | Update N value |
| upd_m | input | M_W | Update M value |
| sys_rst_pull | output | 1 | 1 = pull the open-drain reset line low |
| rec_active | output | 1 | Recovery lock in force |
| wd_status | output | 1 | Sticky timeout status |
| freq_src | output | 2 | Selected source: 00 straps, 01 programmed, 10 recovery N/M |
| freq_n | output | N_W | Selected N |
| freq_m | output | M_W | Selected M |
| freq_fs | output | FS_W | Captured strap code |

## Verification
The bench builds the block with SHORT_TICKS=3, LONG_TICKS=5 and PULSE_W=4. With these values every timeout, including the full 31-unit count on both scales, ends within a few hundred clocks. The exact tick of expiry can therefore be checked by counting base ticks one at a time. The short pulse also lets the bench measure the whole width of the reset pulse. Its end can be seen before recovery is released.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    typedef enum logic [1:0] {
        WD_IDLE    = 2'd0,
        WD_ARMED   = 2'd1,
        WD_COUNT   = 2'd2,
        WD_RECOVER = 2'd3
    } wd_state_e;

    typedef enum logic [1:0] {
        SRC_STRAP = 2'b00,
        SRC_PROG  = 2'b01,
        SRC_RECOV = 2'b10
    } freq_src_e;
endpackage

// File: rtl/fwd_prescaler.sv
module fwd_prescaler #(
    parameter int SHORT_TICKS = 150,
    parameter int LONG_TICKS  = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic base_tick,
    input  logic long_sel,
    output logic unit_tick
);
    localparam int MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int PW   = $clog2(MAXT + 1);
    localparam logic [PW-1:0] LIM_S = PW'(SHORT_TICKS - 1);
    localparam logic [PW-1:0] LIM_L = PW'(LONG_TICKS - 1);

    logic [PW-1:0] pre_q;
    logic [PW-1:0] limit;

    always_comb begin
        limit     = long_sel ? LIM_L : LIM_S;
        unit_tick = run && !restart && base_tick && (pre_q >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run || restart) begin
            pre_q <= '0;
        end else if (base_tick) begin
            pre_q <= unit_tick ? '0 : pre_q + 1'b1;
        end
    end

    // R3 / R4: the unit counter never runs past the larger scale
    assert_prescale_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= PW'(MAXT - 1));

    // R10: a restart always clears the unit counter
    assert_prescale_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> pre_q == '0);
endmodule

// File: rtl/fwd_core.sv
module fwd_core
    import fwd_pkg::*;
#(
    parameter int TIMEOUT_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 freq_change,
    input  logic                 unit_tick,
    input  logic [TIMEOUT_W-1:0] timeout,
    input  logic                 clr_wr,
    input  logic                 clr_val,
    output wd_state_e            state,
    output logic                 run,
    output logic                 restart,
    output logic                 expire,
    output logic                 status
);
    wd_state_e            state_q, state_d;
    logic [TIMEOUT_W-1:0] cnt_q;
    logic                 status_q;
    logic                 load;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE: begin
                if (enable) state_d = WD_ARMED;                 // arm
            end
            WD_ARMED: begin
                if (!enable)          state_d = WD_IDLE;        // disarm
                else if (freq_change) state_d = WD_COUNT;       // start
            end
            WD_COUNT: begin
                if (!enable)          state_d = WD_IDLE;        // disarm
                else if (freq_change) state_d = WD_COUNT;       // restart
                else if (unit_tick && cnt_q <= TIMEOUT_W'(1))
                                      state_d = WD_RECOVER;     // expire
            end
            WD_RECOVER: begin
                if (!enable) state_d = WD_IDLE;                 // disarm
            end
            default: state_d = WD_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_IDLE;
        else        state_q <= state_d;
    end

    // outputs of the controller
    always_comb begin
        run     = (state_q == WD_COUNT);
        load    = enable && freq_change &&
                  (state_q == WD_ARMED || state_q == WD_COUNT);
        restart = run && load;
        expire  = run && enable && !freq_change && unit_tick &&
                  (cnt_q <= TIMEOUT_W'(1));
        state   = state_q;
        status  = status_q;
    end

    // countdown register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else if (load || !enable) begin
            cnt_q <= timeout;
        end else if (run && unit_tick && cnt_q > TIMEOUT_W'(1)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // sticky status: set wins over a clearing write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 status_q <= 1'b0;
        else if (expire)            status_q <= 1'b1;
        else if (clr_wr && clr_val) status_q <= 1'b0;
    end

    assert_no_start_without_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_ARMED && !freq_change) |=> state_q != WD_COUNT);

    assert_status_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> status_q);

    assert_status_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q && !(clr_wr && clr_val)) |=> status_q);

    assert_disarm_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> state_q == WD_IDLE);

    assert_restart_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(timeout));
endmodule

// File: rtl/fwd_pulse.sv
module fwd_pulse #(
    parameter int PULSE_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic drive
);
    localparam int CW = $clog2(PULSE_W + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (fire)         cnt_q <= CW'(PULSE_W);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    always_comb drive = (cnt_q != '0);

    // R6: the pulse shortens by exactly one each cycle it is not refired
    assert_pulse_decr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !fire) |=> cnt_q == $past(cnt_q) - CW'(1));
endmodule

// File: rtl/fwd_freq_sel.sv
module fwd_freq_sel
    import fwd_pkg::*;
#(
    parameter int N_W  = 8,
    parameter int M_W  = 7,
    parameter int FS_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lock,
    input  logic            expire,
    input  logic            rec_sel,
    input  logic [N_W-1:0]  rec_n,
    input  logic [M_W-1:0]  rec_m,
    input  logic [FS_W-1:0] strap_fs,
    input  logic            upd_valid,
    input  logic [N_W-1:0]  upd_n,
    input  logic [M_W-1:0]  upd_m,
    output freq_src_e       src,
    output logic [N_W-1:0]  sel_n,
    output logic [M_W-1:0]  sel_m,
    output logic [FS_W-1:0] fs
);
    freq_src_e       src_q;
    logic [N_W-1:0]  n_q;
    logic [M_W-1:0]  m_q;
    logic [FS_W-1:0] fs_q;
    logic            captured_q;

    // strap capture, once after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q       <= '0;
            captured_q <= 1'b0;
        end else if (!captured_q) begin
            fs_q       <= strap_fs;
            captured_q <= 1'b1;
        end
    end

    // selection: expiry first, then a bus update when not locked
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= SRC_STRAP;
            n_q   <= '0;
            m_q   <= '0;
        end else if (expire) begin
            if (rec_sel) begin
                src_q <= SRC_RECOV;
                n_q   <= rec_n;
                m_q   <= rec_m;
            end else begin
                src_q <= SRC_STRAP;
                n_q   <= '0;
                m_q   <= '0;
            end
        end else if (upd_valid && !lock) begin
            src_q <= SRC_PROG;
            n_q   <= upd_n;
            m_q   <= upd_m;
        end
    end

    always_comb begin
        src   = src_q;
        sel_n = n_q;
        sel_m = m_q;
        fs    = fs_q;
    end

    assert_lock_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !expire) |=> ($stable(src_q) && $stable(n_q) && $stable(m_q)));

    assert_strap_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        captured_q |=> $stable(fs_q));
endmodule

// File: rtl/freq_watchdog.sv
module freq_watchdog
    import fwd_pkg::*;
#(
    parameter int SHORT_TICKS = 150,
    parameter int LONG_TICKS  = 2500,
    parameter int TIMEOUT_W   = 5,
    parameter int N_W         = 8,
    parameter int M_W         = 7,
    parameter int FS_W        = 5,
    parameter int PULSE_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 base_tick,
    input  logic                 wd_enable,
    input  logic                 wd_long_scale,
    input  logic [TIMEOUT_W-1:0] wd_timeout,
    input  logic                 wd_rst_en,
    input  logic                 status_wr,
    input  logic                 status_wr_val,
    input  logic                 freq_change,
    input  logic                 rec_sel,
    input  logic [N_W-1:0]       rec_n,
    input  logic [M_W-1:0]       rec_m,
    input  logic [FS_W-1:0]      strap_fs,
    input  logic                 upd_valid,
    input  logic [N_W-1:0]       upd_n,
    input  logic [M_W-1:0]       upd_m,
    output logic                 sys_rst_pull,
    output logic                 rec_active,
    output logic                 wd_status,
    output logic [1:0]           freq_src,
    output logic [N_W-1:0]       freq_n,
    output logic [M_W-1:0]       freq_m,
    output logic [FS_W-1:0]      freq_fs
);
    wd_state_e state;
    freq_src_e src;
    logic      run;
    logic      restart;
    logic      expire;
    logic      unit_tick;
    logic      lock;

    fwd_prescaler #(
        .SHORT_TICKS(SHORT_TICKS),
        .LONG_TICKS (LONG_TICKS)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .restart  (restart),
        .base_tick(base_tick),
        .long_sel (wd_long_scale),
        .unit_tick(unit_tick)
    );

    fwd_core #(
        .TIMEOUT_W(TIMEOUT_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (wd_enable),
        .freq_change(freq_change),
        .unit_tick  (unit_tick),
        .timeout    (wd_timeout),
        .clr_wr     (status_wr),
        .clr_val    (status_wr_val),
        .state      (state),
        .run        (run),
        .restart    (restart),
        .expire     (expire),
        .status     (wd_status)
    );

    fwd_pulse #(
        .PULSE_W(PULSE_W)
    ) u_pulse (
        .clk  (clk),
        .rst_n(rst_n),
        .fire (expire && wd_rst_en),
        .drive(sys_rst_pull)
    );

    always_comb lock = (state == WD_RECOVER);

    fwd_freq_sel #(
        .N_W (N_W),
        .M_W (M_W),
        .FS_W(FS_W)
    ) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock     (lock),
        .expire   (expire),
        .rec_sel  (rec_sel),
        .rec_n    (rec_n),
        .rec_m    (rec_m),
        .strap_fs (strap_fs),
        .upd_valid(upd_valid),
        .upd_n    (upd_n),
        .upd_m    (upd_m),
        .src      (src),
        .sel_n    (freq_n),
        .sel_m    (freq_m),
        .fs       (freq_fs)
    );

    always_comb begin
        rec_active = lock;
        freq_src   = src;
    end

    assert_rec_on_expire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> rec_active);

    assert_pull_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_pull) |-> $past(expire && wd_rst_en));
endmodule

// File: tb/freq_watchdog_tb.sv
`timescale 1ns/1ps
module freq_watchdog_tb;
    localparam int SHORT = 3;
    localparam int LONG  = 5;
    localparam int PW    = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_tick = 1'b0;
    logic       wd_enable = 1'b0;
    logic       wd_long_scale = 1'b0;
    logic [4:0] wd_timeout = 5'd3;
    logic       wd_rst_en = 1'b0;
    logic       status_wr = 1'b0;
    logic       status_wr_val = 1'b0;
    logic       freq_change = 1'b0;
    logic       rec_sel = 1'b0;
    logic [7:0] rec_n = 8'h00;
    logic [6:0] rec_m = 7'h00;
    logic [4:0] strap_fs = 5'b10110;
    logic       upd_valid = 1'b0;
    logic [7:0] upd_n = 8'h00;
    logic [6:0] upd_m = 7'h00;
    logic       sys_rst_pull;
    logic       rec_active;
    logic       wd_status;
    logic [1:0] freq_src;
    logic [7:0] freq_n;
    logic [6:0] freq_m;
    logic [4:0] freq_fs;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    freq_watchdog #(
        .SHORT_TICKS(SHORT),
        .LONG_TICKS (LONG),
        .PULSE_W    (PW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
        .wd_enable(wd_enable), .wd_long_scale(wd_long_scale),
        .wd_timeout(wd_timeout), .wd_rst_en(wd_rst_en),
        .status_wr(status_wr), .status_wr_val(status_wr_val),
        .freq_change(freq_change), .rec_sel(rec_sel), .rec_n(rec_n),
        .rec_m(rec_m), .strap_fs(strap_fs), .upd_valid(upd_valid),
        .upd_n(upd_n), .upd_m(upd_m), .sys_rst_pull(sys_rst_pull),
        .rec_active(rec_active), .wd_status(wd_status),
        .freq_src(freq_src), .freq_n(freq_n), .freq_m(freq_m),
        .freq_fs(freq_fs)
    );

    // vector: {timeout[4:0], long_scale, rst_en, rec_sel}
    localparam logic [7:0] VECS [0:5] = '{
        {5'd2,  1'b0, 1'b1, 1'b1},
        {5'd3,  1'b1, 1'b0, 1'b0},
        {5'd0,  1'b0, 1'b1, 1'b0},
        {5'd1,  1'b1, 1'b1, 1'b1},
        {5'd31, 1'b0, 1'b0, 1'b1},
        {5'd4,  1'b1, 1'b1, 1'b0}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            base_tick = 1'b1;
            step();
            base_tick = 1'b0;
            step();
        end
    endtask

    task automatic strobe_change();
        freq_change = 1'b1;
        step();
        freq_change = 1'b0;
        step();
    endtask

    task automatic write_status(input logic v);
        status_wr = 1'b1;
        status_wr_val = v;
        step();
        status_wr = 1'b0;
        status_wr_val = 1'b0;
        step();
    endtask

    task automatic bus_update(input logic [7:0] n, input logic [6:0] m);
        upd_valid = 1'b1;
        upd_n = n;
        upd_m = m;
        step();
        upd_valid = 1'b0;
        step();
    endtask

    task automatic disarm_and_clear();
        wd_enable = 1'b0;
        step();
        step();
        write_status(1'b1);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #900000;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        step();
        step();
        rst_n = 1'b1;
        step();
        strap_fs = 5'b00001;
        step();
        // R1 reset state
        chk("R1 status", wd_status, 0);
        chk("R1 rec_active", rec_active, 0);
        chk("R1 pull", sys_rst_pull, 0);
        chk("R1 src", freq_src, 2'b00);
        chk("R1 n", freq_n, 0);
        chk("R1 m", freq_m, 0);
        chk("R1 straps", freq_fs, 5'b10110);

        // table walk: R3/R4/R5/R6/R7/R8/R9
        for (int v = 0; v < 6; v++) begin
            logic [4:0] t;
            logic lng, ren, rsel;
            int need;
            int width;
            t = VECS[v][7:3];
            lng = VECS[v][2];
            ren = VECS[v][1];
            rsel = VECS[v][0];
            need = ((t == 0) ? 1 : int'(t)) * (lng ? LONG : SHORT);
            wd_timeout = t;
            wd_long_scale = lng;
            wd_rst_en = ren;
            rec_sel = rsel;
            rec_n = 8'h40 + 8'(v);
            rec_m = 7'h10 + 7'(v);
            wd_enable = 1'b1;
            step();
            strobe_change();
            ticks(need - 1);
            chk(lng ? "R4 no early expiry" : "R3 no early expiry", wd_status, 0);
            chk(lng ? "R4 not in recovery" : "R3 not in recovery", rec_active, 0);
            base_tick = 1'b1;
            step();
            base_tick = 1'b0;
            chk(lng ? "R4 expiry status" : "R3 expiry status", wd_status, 1);
            chk("R7 recovery entered", rec_active, 1);
            chk("R6 pull at expiry", sys_rst_pull, ren);
            width = 0;
            while (sys_rst_pull && width < 50) begin
                width++;
                step();
            end
            chk("R6 pulse width", width, ren ? PW : 0);
            chk("R7 src", freq_src, rsel ? 2'b10 : 2'b00);
            chk("R7 n", freq_n, rsel ? 8'h40 + 8'(v) : 8'h00);
            chk("R7 m", freq_m, rsel ? 7'h10 + 7'(v) : 7'h00);
            bus_update(8'hAA, 7'h55);
            chk("R8 locked src", freq_src, rsel ? 2'b10 : 2'b00);
            chk("R8 locked n", freq_n, rsel ? 8'h40 + 8'(v) : 8'h00);
            wd_enable = 1'b0;
            step();
            step();
            chk("R9 recovery left", rec_active, 0);
            chk("R5 sticky after disarm", wd_status, 1);
            write_status(1'b0);
            chk("R5 write 0 ignored", wd_status, 1);
            write_status(1'b1);
            chk("R5 write 1 clears", wd_status, 0);
            bus_update(8'h12 + 8'(v), 7'h21);
            chk("R8 update src", freq_src, 2'b01);
            chk("R8 update n", freq_n, 8'h12 + 8'(v));
            chk("R8 update m", freq_m, 7'h21);
        end

        // R2: armed without a change strobe never expires
        wd_timeout = 5'd1;
        wd_long_scale = 1'b0;
        wd_rst_en = 1'b1;
        wd_enable = 1'b1;
        step();
        ticks(40);
        chk("R2 no expiry without change", wd_status, 0);
        chk("R2 no pull without change", sys_rst_pull, 0);

        // R10: restart reloads the full count (3 units * 3 ticks)
        wd_timeout = 5'd3;
        strobe_change();
        ticks(7);
        strobe_change();
        ticks(8);
        chk("R10 no expiry after restart", wd_status, 0);
        ticks(1);
        chk("R10 expiry after full reload", wd_status, 1);
        disarm_and_clear();

        // R9: disarm mid-count stops; re-arm needs a fresh strobe and full length
        wd_enable = 1'b1;
        step();
        strobe_change();
        ticks(5);
        wd_enable = 1'b0;
        step();
        wd_enable = 1'b1;
        step();
        ticks(20);
        chk("R9 stopped after disarm", wd_status, 0);
        strobe_change();
        ticks(8);
        chk("R9 reloaded full length", wd_status, 0);
        ticks(1);
        chk("R9 expiry after fresh strobe", wd_status, 1);

        // R5: timeout in the same cycle as a clearing write wins
        disarm_and_clear();
        wd_timeout = 5'd1;
        wd_enable = 1'b1;
        step();
        strobe_change();
        ticks(2);
        base_tick = 1'b1;
        status_wr = 1'b1;
        status_wr_val = 1'b1;
        step();
        base_tick = 1'b0;
        status_wr = 1'b0;
        status_wr_val = 1'b0;
        chk("R5 set wins over clear", wd_status, 1);

        finish_run();
    end
endmodule